// File: doc/BRIEF.md
# Dual-Region Field CRC Checker

This block keeps two running CRC-16 checksums over a stream of 10-bit video words, one for the active picture region and one for the full field region. A separate enable for each region marks which words count toward it; those enables come from timing logic outside the block. A strobe at the end of each field closes both checksums, publishes them on output ports and restarts both accumulators from zero.

In transmit mode the published values are meant for building the outgoing error-check packet, and both error flags are held low. In receive mode the block compares each finished checksum with a received value that a packet parser presents on input ports together with a valid strobe. A mismatch raises the flag for that region only. The flags then hold for one field. Before it enters either checksum, any word whose upper eight bits are all ones is forced to all ones, so an 8-bit source and a 10-bit source give the same result.

Top module: `field_crc_pair`

## Requirements
- R1: Each enabled word advances a checksum by one step per bit, taking the 10 bits least significant first. For each bit b, the step is: f = b XOR crc[0]; crc = crc >> 1; if f then crc ^= 16'h8408. This is the bit-reversed form of x^16 + x^12 + x^5 + 1. Both checksums start each field at zero.
- R2: A word from 10'h3FC to 10'h3FF inclusive is treated as 10'h3FF before it enters either checksum. A word of 10'h3FB is used unchanged.
- R3: The active picture checksum advances only in cycles where `ap_en` is high, and the full field checksum only in cycles where `ff_en` is high. The two are independent.
- R4: In a cycle with `field_end` high, the word on `word_in` is not accumulated. On the next clock, `ap_crc_out` and `ff_crc_out` take the values accumulated over the field and both accumulators return to zero. The outputs change at no other time.
- R5: On the clock that ends a field in receive mode (`rx_mode` high), if a received value was strobed by `rx_crc_valid` during that field, `ap_err` is set to (calculated != `rx_ap_crc`) and `ff_err` is set to (calculated != `rx_ff_crc`). A strobe in the `field_end` cycle itself counts, and the last strobe in a field wins.
- R6: If no `rx_crc_valid` strobe occurred during a field, both flags are 0 after that field ends.
- R7: Any cycle with `rx_mode` low drives both flags to 0 on the next clock, and no field end in transmit mode sets them.
- R8: In receive mode the flags keep their value from one field end to the next.
- R9: While `rst_n` is low, both checksum outputs and both flags are 0, and any stored received value is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_in | input | DATA_W | Video data word |
| ap_en | input | 1 | Word belongs to the active picture region |
| ff_en | input | 1 | Word belongs to the full field region |
| field_end | input | 1 | Closes the current field |
| rx_mode | input | 1 | 1 = receive (compare), 0 = transmit |
| rx_crc_valid | input | 1 | Received checksums on the next two ports are valid |
| rx_ap_crc | input | CRC_W | Received active picture checksum |
| rx_ff_crc | input | CRC_W | Received full field checksum |
| ap_crc_out | output | CRC_W | Active picture checksum of the last field |
| ff_crc_out | output | CRC_W | Full field checksum of the last field |
| ap_err | output | 1 | Active picture mismatch flag |
| ff_err | output | 1 | Full field mismatch flag |

## Verification
The bench builds the block with its default parameters: 10-bit words, a 16-bit checksum and the reversed constant 16'h8408. These values make the saturation band 3FC–3FF reachable, so a word just below the band can be set against the band's edges. The bench feeds short 24-word fields in which the active region covers the middle twelve words. Within a few hundred cycles this covers every combination of region mismatch, the missing-strobe and transmit cases, a strobe that coincides with the field end, and flag persistence into the following field.

// File: rtl/field_crc_pair.sv
module field_crc_pair #(
  parameter int DATA_W = 10,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY_REV = 16'h8408
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] word_in,
  input  logic              ap_en,
  input  logic              ff_en,
  input  logic              field_end,
  input  logic              rx_mode,
  input  logic              rx_crc_valid,
  input  logic [CRC_W-1:0]  rx_ap_crc,
  input  logic [CRC_W-1:0]  rx_ff_crc,
  output logic [CRC_W-1:0]  ap_crc_out,
  output logic [CRC_W-1:0]  ff_crc_out,
  output logic              ap_err,
  output logic              ff_err
);

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [DATA_W-1:0] w);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < DATA_W; i++) begin
      if (r[0] ^ w[i]) r = (r >> 1) ^ CRC_POLY_REV;
      else             r = r >> 1;
    end
    return r;
  endfunction

  logic [CRC_W-1:0]  ap_acc, ff_acc;
  logic [CRC_W-1:0]  rx_ap_q, rx_ff_q;
  logic              rx_seen;
  logic [DATA_W-1:0] word_rc;
  logic [CRC_W-1:0]  ap_next, ff_next, ap_ref, ff_ref;
  logic              have_ref;

  assign word_rc  = (&word_in[DATA_W-1:2]) ? '1 : word_in;
  assign ap_next  = crc_step(ap_acc, word_rc);
  assign ff_next  = crc_step(ff_acc, word_rc);
  assign ap_ref   = rx_crc_valid ? rx_ap_crc : rx_ap_q;
  assign ff_ref   = rx_crc_valid ? rx_ff_crc : rx_ff_q;
  assign have_ref = rx_crc_valid | rx_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ap_acc     <= '0;
      ff_acc     <= '0;
      ap_crc_out <= '0;
      ff_crc_out <= '0;
      rx_ap_q    <= '0;
      rx_ff_q    <= '0;
      rx_seen    <= 1'b0;
      ap_err     <= 1'b0;
      ff_err     <= 1'b0;
    end else if (field_end) begin
      ap_acc     <= '0;
      ff_acc     <= '0;
      ap_crc_out <= ap_acc;
      ff_crc_out <= ff_acc;
      rx_seen    <= 1'b0;
      ap_err     <= rx_mode & have_ref & (ap_acc != ap_ref);
      ff_err     <= rx_mode & have_ref & (ff_acc != ff_ref);
    end else begin
      if (ap_en) ap_acc <= ap_next;
      if (ff_en) ff_acc <= ff_next;
      if (rx_crc_valid) begin
        rx_ap_q <= rx_ap_crc;
        rx_ff_q <= rx_ff_crc;
        rx_seen <= 1'b1;
      end
      if (!rx_mode) begin
        ap_err <= 1'b0;
        ff_err <= 1'b0;
      end
    end
  end

endmodule

module field_crc_pair_chk #(
  parameter int CRC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             field_end,
  input logic             rx_mode,
  input logic             rx_crc_valid,
  input logic [CRC_W-1:0] ap_crc_out,
  input logic [CRC_W-1:0] ff_crc_out,
  input logic             ap_err,
  input logic             ff_err
);
  logic strobe_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)         strobe_seen <= 1'b0;
    else if (field_end) strobe_seen <= 1'b0;
    else if (rx_crc_valid) strobe_seen <= 1'b1;
  end

  // R7
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_mode |=> (!ap_err && !ff_err));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode && !field_end) |=> ($stable(ap_err) && $stable(ff_err)));

  // R4
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !field_end |=> ($stable(ap_crc_out) && $stable(ff_crc_out)));

  // R6
  no_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (field_end && !strobe_seen && !rx_crc_valid) |=> (!ap_err && !ff_err));
endmodule

bind field_crc_pair field_crc_pair_chk #(.CRC_W(CRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .field_end(field_end), .rx_mode(rx_mode),
  .rx_crc_valid(rx_crc_valid), .ap_crc_out(ap_crc_out),
  .ff_crc_out(ff_crc_out), .ap_err(ap_err), .ff_err(ff_err)
);

// File: tb/field_crc_pair_test.sv
`timescale 1ns/1ps
module field_crc_pair_test;
  localparam int N = 24;
  localparam int AP_LO = 6;
  localparam int AP_HI = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] word_in = '0;
  logic ap_en = 1'b0, ff_en = 1'b0, field_end = 1'b0, rx_mode = 1'b1, rx_crc_valid = 1'b0;
  logic [15:0] rx_ap_crc = '0, rx_ff_crc = '0;
  logic [15:0] ap_crc_out, ff_crc_out;
  logic ap_err, ff_err;

  int tests = 0, fails = 0;
  logic prev_ap = 1'b0, prev_ff = 1'b0;
  logic [15:0] last_ap, last_ff;

  always #2.5 clk = ~clk;

  field_crc_pair uut (.*);

  // rows: {rx_mode, strobe, corrupt_ap, corrupt_ff, seed}
  localparam logic [19:0] VEC [7] = '{
    {4'b1100, 16'h0001}, {4'b1110, 16'h1234}, {4'b1101, 16'hBEEF},
    {4'b1111, 16'h0F0F}, {4'b1011, 16'h7777}, {4'b0111, 16'hA5A5},
    {4'b1100, 16'h4321}};

  function automatic logic [15:0] model(input logic [15:0] c, input logic [9:0] w);
    logic [15:0] r = c;
    logic [9:0] v = (w >= 10'h3FC) ? 10'h3FF : w;
    for (int b = 0; b < 10; b++) begin
      logic f = v[b] ^ r[0];
      r = r >> 1;
      if (f) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  function automatic logic [9:0] gen(input logic [15:0] seed, input int i);
    logic [31:0] t = (32'(seed) + 32'(i) * 397) * 13;
    if (i % 7 == 3) return 10'h3FC + 10'(i % 4);
    return t[13:4];
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_field(input logic [15:0] seed, input logic rxm, input logic val,
                            input logic val_end, input logic xap, input logic xff,
                            input int pidx, input logic [9:0] pval);
    logic [15:0] eap = '0, eff = '0;
    logic [9:0] w [N];
    for (int i = 0; i < N; i++) begin
      w[i] = (i == pidx) ? pval : gen(seed, i);
      if (i >= AP_LO && i <= AP_HI) eap = model(eap, w[i]);
      eff = model(eff, w[i]);
    end
    rx_mode = rxm;
    rx_ap_crc = eap ^ (xap ? 16'h0040 : 16'h0);
    rx_ff_crc = eff ^ (xff ? 16'h8001 : 16'h0);
    for (int i = 0; i < N; i++) begin
      word_in = w[i];
      ap_en = (i >= AP_LO && i <= AP_HI);
      ff_en = 1'b1;
      rx_crc_valid = val && !val_end && (i == 20);
      @(posedge clk); @(negedge clk);
      if (i == 2) begin
        check("R8 ap_err held into next field", 16'(ap_err), 16'(rxm & prev_ap));
        check("R8 ff_err held into next field", 16'(ff_err), 16'(rxm & prev_ff));
      end
    end
    word_in = 10'h155; ap_en = 1'b1; ff_en = 1'b1; field_end = 1'b1;
    rx_crc_valid = val && val_end;
    @(posedge clk); @(negedge clk);
    field_end = 1'b0; ap_en = 1'b0; ff_en = 1'b0; rx_crc_valid = 1'b0;
    prev_ap = rxm & val & xap;
    prev_ff = rxm & val & xff;
    check("R1 R3 R4 ap_crc_out", ap_crc_out, eap);
    check("R1 R3 R4 ff_crc_out", ff_crc_out, eff);
    check("R5 R6 R7 ap_err", 16'(ap_err), 16'(prev_ap));
    check("R5 R6 R7 ff_err", 16'(ff_err), 16'(prev_ff));
    last_ap = ap_crc_out;
    last_ff = ff_crc_out;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] a0, f0;
    repeat (3) @(negedge clk);
    check("R9 reset ap_crc_out", ap_crc_out, 16'h0);
    check("R9 reset ff_crc_out", ff_crc_out, 16'h0);
    check("R9 reset flags", {14'h0, ap_err, ff_err}, 16'h0);
    rst_n = 1'b1;

    foreach (VEC[k])
      send_field(VEC[k][15:0], VEC[k][19], VEC[k][18], 1'b0, VEC[k][17], VEC[k][16], -1, 10'h0);

    // R2: band edges 3FC and 3FF give the same sums, 3FB does not
    send_field(16'h0055, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8, 10'h3FC);
    a0 = last_ap; f0 = last_ff;
    send_field(16'h0055, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8, 10'h3FF);
    check("R2 3FC vs 3FF ap", last_ap, a0);
    check("R2 3FC vs 3FF ff", last_ff, f0);
    send_field(16'h0055, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8, 10'h3FB);
    check("R2 3FB distinct ff", 16'(last_ff != f0), 16'h1);

    // R5: strobe in the field_end cycle counts
    send_field(16'h2222, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, -1, 10'h0);

    // R7: one transmit cycle mid-field clears a held flag
    rx_mode = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R7 tx clears ap_err", 16'(ap_err), 16'h0);
    rx_mode = 1'b1;
    prev_ap = 1'b0; prev_ff = 1'b0;

    send_field(16'h3333, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, -1, 10'h0);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R9 mid-run reset ap_crc_out", ap_crc_out, 16'h0);
    check("R9 mid-run reset flags", {14'h0, ap_err, ff_err}, 16'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule